// File: doc/BRIEF.md
# Vertical Subsampling Frame-Shift Generator

This block drives the four image-section clock phases and the four storage-section clock phases of a frame-transfer image sensor during a fast monitor-mode frame shift. One start pulse sets off a full shift in three sections. First a preamble of lines moves without subsampling: these are the dark and padding rows at the top of the array. Next comes the active section. Here the image section is clocked on every line step, but the storage section is clocked only on a chosen number of steps out of each group. Last, a tail flush clocks both sections together. This clears the leftover image rows and the unused gap lines at the end of storage.

The control logic pulses a transport-rate tick at the shift frequency, about 1.56 MHz in a typical system. Each tick moves the phase pattern by exactly one edge. The group length N and the number K of storage steps per group set the subsampling ratio. For example, N=10 with K=2 turns 1290 active rows into 258 stored rows, and N=5 with K=1 gives a 1:5 reduction. A one-cycle completion pulse marks the end of the shift.

Top module: `fshift_subsample_gen`

## Requirements
- R1: After reset, both phase buses sit at the idle pattern 4'b0011, where bit 0 is phase 1 and bit 3 is phase 4, so phases 1 and 2 are high. The group counter reads 0 and `shift_done` is low.
- R2: While a shift runs, each tick moves the image phases one step through the 8-entry sequence 0011, 0111, 0110, 1110, 1100, 1101, 1001, 1011. The 8th tick returns them to 0011, which ends one line step. Exactly one phase bit changes per tick.
- R3: In cycles without a tick, all outputs hold their values.
- R4: The first PRE_LINES line steps are the preamble. In each of them the storage phases follow the same pattern as the image phases.
- R5: The next ACT_LINES line steps form the active section. The group counter gives the index of the step within its group of N, counting 0 to N-1 and then wrapping. The storage phases follow the image phases only on steps whose index is below K; on all other steps they stay at 0011.
- R6: The last TAIL_LINES line steps are the tail flush. In them both phase buses step together and the group counter reads 0.
- R7: `shift_done` is high for exactly one cycle, in the cycle after the final tick of the last tail step. At that point both buses are idle.
- R8: A start pulse that arrives while a shift runs is ignored. The running shift goes on with its original ratio, and the outputs do not change in that cycle.
- R9: The ratio is captured at start. A group length of 0 is treated as 1, and a K of N or more makes the storage section move on every active step.
- R10: Ticks received while idle have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts one frame shift when idle |
| xfer_tick | input | 1 | Transport-rate tick; one phase edge per tick |
| grp_len | input | RW | Image steps per subsampling group (N) |
| grp_keep | input | RW | Storage steps per group (K) |
| img_ph | output | 4 | Image-section phases, bit 0 = phase 1 |
| sto_ph | output | 4 | Storage-section phases, bit 0 = phase 1 |
| fs_count | output | RW | Step index within the current group |
| shift_done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs full shifts for every group length from 0 to 6 and every keep count from 0 to 7. This covers the cases with no storage steps, the normal subsampling cases, and K equal to or above N. For each ratio it checks the storage bus and the group counter on every tick against a step-by-step model of the three sections. A wrong group wrap, a preamble or tail of the wrong length, or a storage gate applied in the wrong section each shows up as a mismatch at a distinct step. Extra start pulses in the middle of a shift, ticks while idle, and the cycles held between ticks show whether the block reacts only to the inputs it should.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [1:0] {S_IDLE, S_PRE, S_ACT, S_TAIL} fsg_state_t;

  localparam logic [3:0] PH_IDLE = 4'b0011;

  function automatic logic [3:0] ph_pattern(input logic [2:0] idx);
    logic [3:0] p;
    case (idx)
      3'd0: p = 4'b0011;
      3'd1: p = 4'b0111;
      3'd2: p = 4'b0110;
      3'd3: p = 4'b1110;
      3'd4: p = 4'b1100;
      3'd5: p = 4'b1101;
      3'd6: p = 4'b1001;
      default: p = 4'b1011;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/fsg_phase_gen.sv
module fsg_phase_gen
  import fsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  input  logic       sto_en,
  output logic [3:0] img_ph,
  output logic [3:0] sto_ph,
  output logic       step_end
);
  logic [2:0] idx;
  logic [2:0] idx_nx;

  assign idx_nx   = idx + 3'd1;
  assign step_end = adv && (idx == 3'd7);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      img_ph <= PH_IDLE;
      sto_ph <= PH_IDLE;
    end else if (adv) begin
      idx    <= idx_nx;
      img_ph <= ph_pattern(idx_nx);
      sto_ph <= sto_en ? ph_pattern(idx_nx) : PH_IDLE;
    end
  end

  p_one_edge_r2: assert property (@(posedge clk) disable iff (rst)
    adv |=> ($countones(img_ph ^ $past(img_ph)) == 1));
  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(img_ph) && $stable(sto_ph)));
  p_overlap_r2: assert property (@(posedge clk) disable iff (rst)
    ($countones(img_ph) == 2) || ($countones(img_ph) == 3));
endmodule

// File: rtl/fsg_group_cnt.sv
module fsg_group_cnt #(
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic [RW-1:0] n_lim,
  input  logic [RW-1:0] k_lim,
  output logic [RW-1:0] fs,
  output logic          store_en
);
  localparam logic [RW-1:0] ONE = RW'(1);

  assign store_en = (fs < k_lim);

  always_ff @(posedge clk) begin
    if (rst || clr)
      fs <= '0;
    else if (adv)
      fs <= (fs == n_lim - ONE) ? '0 : fs + ONE;
  end

  p_fs_below_group_r5: assert property (@(posedge clk) disable iff (rst)
    (n_lim != '0) |-> (fs < n_lim));
endmodule

// File: rtl/fshift_subsample_gen.sv
module fshift_subsample_gen
  import fsg_pkg::*;
#(
  parameter int PRE_LINES  = 16,
  parameter int ACT_LINES  = 1290,
  parameter int TAIL_LINES = 12,
  parameter int RW         = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          xfer_tick,
  input  logic [RW-1:0] grp_len,
  input  logic [RW-1:0] grp_keep,
  output logic [3:0]    img_ph,
  output logic [3:0]    sto_ph,
  output logic [RW-1:0] fs_count,
  output logic          shift_done
);
  localparam int MAXL_A = (PRE_LINES > ACT_LINES) ? PRE_LINES : ACT_LINES;
  localparam int MAXL   = (MAXL_A > TAIL_LINES) ? MAXL_A : TAIL_LINES;
  localparam int LW     = $clog2(MAXL + 1);
  localparam logic [LW-1:0] PRE_LAST  = LW'(PRE_LINES - 1);
  localparam logic [LW-1:0] ACT_LAST  = LW'(ACT_LINES - 1);
  localparam logic [LW-1:0] TAIL_LAST = LW'(TAIL_LINES - 1);

  fsg_state_t     st;
  logic [LW-1:0]  line_cnt;
  logic [RW-1:0]  n_q, k_q;
  logic           busy, adv, step_end, store_en, sto_en;
  logic           fs_clr, fs_adv, sec_last;

  assign busy   = (st != S_IDLE);
  assign adv    = busy && xfer_tick;
  assign sto_en = (st == S_ACT) ? store_en : 1'b1;

  always_comb begin
    case (st)
      S_PRE:   sec_last = (line_cnt == PRE_LAST);
      S_ACT:   sec_last = (line_cnt == ACT_LAST);
      S_TAIL:  sec_last = (line_cnt == TAIL_LAST);
      default: sec_last = 1'b0;
    endcase
  end

  assign fs_adv = step_end && (st == S_ACT) && !sec_last;
  assign fs_clr = (st == S_IDLE) || (step_end && (st == S_ACT) && sec_last);

  fsg_phase_gen u_phase (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .sto_en   (sto_en),
    .img_ph   (img_ph),
    .sto_ph   (sto_ph),
    .step_end (step_end)
  );

  fsg_group_cnt #(.RW(RW)) u_group (
    .clk      (clk),
    .rst      (rst),
    .clr      (fs_clr),
    .adv      (fs_adv),
    .n_lim    (n_q),
    .k_lim    (k_q),
    .fs       (fs_count),
    .store_en (store_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      line_cnt   <= '0;
      n_q        <= RW'(1);
      k_q        <= '0;
      shift_done <= 1'b0;
    end else begin
      shift_done <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          st       <= S_PRE;
          line_cnt <= '0;
          n_q      <= (grp_len == '0) ? RW'(1) : grp_len;
          k_q      <= grp_keep;
        end
      end else if (step_end) begin
        if (sec_last) begin
          line_cnt <= '0;
          case (st)
            S_PRE:   st <= S_ACT;
            S_ACT:   st <= S_TAIL;
            default: begin
              st         <= S_IDLE;
              shift_done <= 1'b1;
            end
          endcase
        end else begin
          line_cnt <= line_cnt + LW'(1);
        end
      end
    end
  end

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    shift_done |=> !shift_done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    shift_done |-> (img_ph == PH_IDLE && sto_ph == PH_IDLE && !busy));
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !xfer_tick) |=> ($stable(img_ph) && $stable(sto_ph) && $stable(fs_count)));
  p_idle_tick_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(img_ph) && $stable(sto_ph)));
  p_skip_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (st == S_ACT && !store_en && xfer_tick) |=> (sto_ph == PH_IDLE));
endmodule

// File: tb/fshift_subsample_gen_tb.sv
`timescale 1ns/1ps
module fshift_subsample_gen_tb_top;
  localparam int PRE  = 3;
  localparam int ACT  = 11;
  localparam int TAIL = 2;
  localparam int RW   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic xfer_tick = 1'b0;
  logic [RW-1:0] grp_len = '0, grp_keep = '0;
  logic [3:0] img_ph, sto_ph;
  logic [RW-1:0] fs_count;
  logic shift_done;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;

  fshift_subsample_gen #(.PRE_LINES(PRE), .ACT_LINES(ACT), .TAIL_LINES(TAIL), .RW(RW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .xfer_tick(xfer_tick),
    .grp_len(grp_len), .grp_keep(grp_keep),
    .img_ph(img_ph), .sto_ph(sto_ph), .fs_count(fs_count), .shift_done(shift_done)
  );

  function automatic logic [3:0] exp_pat(input int j);
    case (j % 8)
      0: return 4'b0011;
      1: return 4'b0111;
      2: return 4'b0110;
      3: return 4'b1110;
      4: return 4'b1100;
      5: return 4'b1101;
      6: return 4'b1001;
      default: return 4'b1011;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report_and_end();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
      report_and_end();
    end
  end

  // one tick; before raising it, confirm the outputs held through a tick-free cycle (R3)
  task automatic do_tick(input logic chk_hold);
    logic [3:0] a0, b0;
    @(negedge clk);
    if (chk_hold) begin
      a0 = img_ph; b0 = sto_ph;
      @(negedge clk);
      chk("R3 img hold", img_ph, a0);
      chk("R3 sto hold", sto_ph, b0);
    end
    xfer_tick = 1'b1;
    @(negedge clk);
    xfer_tick = 1'b0;
  endtask

  task automatic pulse_start(input int n, input int k);
    @(negedge clk);
    grp_len = RW'(n); grp_keep = RW'(k); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_frame(input int n, input int k, input logic poke);
    int neff;
    neff = (n == 0) ? 1 : n;
    pulse_start(n, k);
    for (int s = 0; s < PRE + ACT + TAIL; s++) begin
      logic ben;
      int fsm;
      fsm = 0;
      if (s < PRE) ben = 1'b1;
      else if (s < PRE + ACT) begin
        fsm = (s - PRE) % neff;
        ben = (fsm < k);
      end else ben = 1'b1;
      for (int j = 1; j <= 8; j++) begin
        if (poke && s == PRE + 2 && j == 3) begin
          logic [3:0] a0, b0;
          a0 = img_ph; b0 = sto_ph;
          pulse_start((n + 3) % 7, (k + 5) % 8);
          chk("R8 img after stray start", img_ph, a0);
          chk("R8 sto after stray start", sto_ph, b0);
        end
        do_tick(j == 4);
        chk("R2 img phase", img_ph, exp_pat(j));
        if (s < PRE)
          chk("R4 sto preamble", sto_ph, exp_pat(j));
        else if (s < PRE + ACT)
          chk("R5 R9 sto active", sto_ph, ben ? exp_pat(j) : 4'b0011);
        else
          chk("R6 sto tail", sto_ph, exp_pat(j));
        if (j < 8) begin
          if (s >= PRE && s < PRE + ACT) chk("R5 fs count", fs_count, fsm);
          else chk("R6 fs zero", fs_count, 0);
        end
        if (s == PRE + ACT + TAIL - 1 && j == 8)
          chk("R7 done pulse", shift_done, 1);
        else
          chk("R7 no early done", shift_done, 0);
      end
    end
    @(negedge clk);
    chk("R7 done one cycle", shift_done, 0);
    chk("R7 img idle", img_ph, 4'b0011);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 img idle", img_ph, 4'b0011);
    chk("R1 sto idle", sto_ph, 4'b0011);
    chk("R1 fs zero", fs_count, 0);
    chk("R1 done low", shift_done, 0);
    for (int i = 0; i < 5; i++) begin
      do_tick(1'b0);
      chk("R10 idle tick img", img_ph, 4'b0011);
      chk("R10 idle tick sto", sto_ph, 4'b0011);
      chk("R10 idle tick done", shift_done, 0);
    end
    for (int n = 0; n <= 6; n++)
      for (int k = 0; k <= 7; k++)
        run_frame(n, k, k == 1);
    report_and_end();
  end
endmodule